// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer with Lockdown

This block is a fully associative translation cache. It holds 64 resolved mappings, and each mapping may be a 1MB section, a 64KB large page, a 4KB small page or a 1KB tiny page. All four sizes share one entry array. On a lookup, each entry compares only the virtual address bits above its own page offset. On a hit, the physical address is the stored base with the page offset taken from the lookup address. One instance serves either the instruction side or the data side, and each instance has its own lockdown setting.

A table walker loads mappings through the refill port. The entry that gets overwritten is chosen by a cyclic pointer that stays inside the unlocked region: entries below the lockdown base are never chosen. There are two control inputs for invalidation. One clears all unlocked entries at once. The other clears every entry that covers a given address, whether it is locked or not.

The lookup request and the lookup result each use a valid/ready handshake. The result stage holds one result. A new request is taken only when that stage is empty or is being emptied in the same cycle. While the result is stalled, it is held unchanged. If two entries ever match, the lowest index wins. A walker that never loads overlapping mappings never creates that case.

Top module: `tlb_multisize`

## Requirements
- R1: A lookup that hits a section entry returns PA = {base[31:20], va[19:0]}.
- R2: The size code is 00 for a section (offset va[19:0]), 01 for a large page (offset va[15:0]), 10 for a small page (offset va[11:0]) and 11 for a tiny page (offset va[9:0]). An entry matches when the tag bits above its offset are equal. The physical address is the stored base above the offset, concatenated with the offset.
- R3: `lk_ready` is high exactly when the result stage is empty or `rs_ready` is high. An accepted lookup gives `rs_valid` on the next cycle. While `rs_valid` is high and `rs_ready` is low, `rs_hit`, `rs_pa` and `rs_size` do not change.
- R4: A lookup that matches no valid entry returns `rs_hit`=0, `rs_pa`=0 and `rs_size`=0.
- R5: An accepted refill writes the victim entry in that cycle. The victim is the cyclic pointer, raised to `lock_base` if the pointer is below it. After each write the pointer moves to victim+1, and it wraps from entry 63 back to `lock_base`. After reset the pointer is 0.
- R6: No refill ever overwrites an entry whose index is below `lock_base`.
- R7: `inv_all` clears every entry whose index is at or above `lock_base`, and leaves locked entries valid.
- R8: `inv_one` clears every entry, locked or not, whose size-masked tag equals `inv_tag`.
- R9: During any cycle with `inv_all` or `inv_one` high, `rf_ready` is low and no refill is written. A lookup accepted in that cycle sees the contents from before the invalidation.
- R10: If refills never load overlapping mappings, at most one entry ever matches a lookup, and every hit returns that entry's translation.
- R11: After reset all entries are invalid, `rs_valid` is 0, and `lk_ready` and `rf_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_va | input | 32 | Modified virtual address to translate |
| rs_valid | output | 1 | Lookup result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_hit | output | 1 | Result is a hit |
| rs_pa | output | 32 | Translated physical address (0 on a miss) |
| rs_size | output | 2 | Size code of the hit entry (0 on a miss) |
| rf_valid | input | 1 | Refill mapping valid |
| rf_ready | output | 1 | Refill accepted (low during invalidation) |
| rf_tag | input | 22 | Virtual address bits [31:10] of the mapping |
| rf_base | input | 22 | Physical base bits [31:10] of the mapping |
| rf_size | input | 2 | Size code of the mapping |
| inv_all | input | 1 | Invalidate all unlocked entries |
| inv_one | input | 1 | Invalidate every entry that covers inv_tag |
| inv_tag | input | 22 | Address bits [31:10] for single invalidation |
| lock_base | input | 6 | First unlocked entry index |

## Verification
The hardest situation to reach is eviction under lockdown. The pointer has to wrap several times past the unlocked region while the locked mappings survive. This takes many more refills than there are entries, and none of them may overlap a live mapping. The stimulus draws random sizes and addresses, rejects any mapping that would overlap a live one in the bench model, and then sweeps lookups over every tag ever loaded. A collision of invalidation with a refill and a lookup in the same cycle is forced by a directed step.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int TAG_LSB = 10;
  localparam int TAG_W  = VA_W - TAG_LSB;

  typedef enum logic [1:0] {
    SZ_SECTION = 2'b00,
    SZ_LARGE   = 2'b01,
    SZ_SMALL   = 2'b10,
    SZ_TINY    = 2'b11
  } pg_size_e;

  // Tag bits (VA[31:10]) that take part in the compare for each size.
  function automatic logic [TAG_W-1:0] tag_mask(input pg_size_e sz);
    logic [TAG_W-1:0] m;
    case (sz)
      SZ_SECTION: m = {{12{1'b1}}, {10{1'b0}}};
      SZ_LARGE:   m = {{16{1'b1}}, {6{1'b0}}};
      SZ_SMALL:   m = {{20{1'b1}}, {2{1'b0}}};
      default:    m = {TAG_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam
  import tlb_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [N-1:0][1:0]       ent_size,
  input  logic [TAG_W-1:0]        probe,
  output logic [N-1:0]            match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [TAG_W-1:0] care;
    assign care     = tag_mask(pg_size_e'(ent_size[i]));
    assign match[i] = ent_valid[i] && (((ent_tag[i] ^ probe) & care) == '0);
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_victim_rr.sv
module tlb_victim_rr #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] lock_base,
  input  logic          advance,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_nxt;

  always_comb begin
    victim  = (ptr_q < lock_base) ? lock_base : ptr_q;
    ptr_nxt = (victim == IW'(N - 1)) ? lock_base : victim + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import tlb_pkg::*;
#(
  parameter  int N_ENTRIES = 64,
  localparam int IW        = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_va,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic             rs_hit,
  output logic [VA_W-1:0]  rs_pa,
  output logic [1:0]       rs_size,
  input  logic             rf_valid,
  output logic             rf_ready,
  input  logic [TAG_W-1:0] rf_tag,
  input  logic [TAG_W-1:0] rf_base,
  input  logic [1:0]       rf_size,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic [IW-1:0]    lock_base
);
  localparam int N = N_ENTRIES;

  // Entry storage
  logic [N-1:0]            ent_valid;
  logic [N-1:0][TAG_W-1:0] ent_tag;
  logic [N-1:0][TAG_W-1:0] ent_base;
  logic [N-1:0][1:0]       ent_size;

  // Lookup path
  logic [N-1:0]  lk_match;
  logic          lk_any;
  logic [IW-1:0] lk_idx;
  logic          lk_fire;
  logic [TAG_W-1:0] hit_mask;
  logic [VA_W-1:0]  hit_pa;

  // Invalidate / refill path
  logic [N-1:0]  inv_match;
  logic [N-1:0]  unlocked;
  logic [N-1:0]  clr_vec;
  logic [IW-1:0] victim;
  logic          rf_fire;

  tlb_tag_cam #(.N(N)) u_cam_lk (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_size(ent_size),
    .probe(lk_va[VA_W-1:TAG_LSB]), .match(lk_match)
  );

  tlb_tag_cam #(.N(N)) u_cam_inv (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_size(ent_size),
    .probe(inv_tag), .match(inv_match)
  );

  tlb_first_hit #(.N(N), .IW(IW)) u_first (
    .vec(lk_match), .any(lk_any), .idx(lk_idx)
  );

  tlb_victim_rr #(.N(N), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .lock_base(lock_base),
    .advance(rf_fire), .victim(victim)
  );

  for (genvar i = 0; i < N; i++) begin : g_lock
    assign unlocked[i] = (IW'(i) >= lock_base);
  end

  // Invalidation takes the cycle; refill waits.
  assign rf_ready = !(inv_all || inv_one);
  assign rf_fire  = rf_valid && rf_ready;

  always_comb begin
    clr_vec = '0;
    if (inv_all) clr_vec = clr_vec | unlocked;
    if (inv_one) clr_vec = clr_vec | inv_match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (inv_all || inv_one) begin
      ent_valid <= ent_valid & ~clr_vec;
    end else if (rf_fire) begin
      ent_valid[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_fire) begin
      ent_tag[victim]  <= rf_tag;
      ent_base[victim] <= rf_base;
      ent_size[victim] <= rf_size;
    end
  end

  // Translation of the winning entry
  always_comb begin
    hit_mask = tag_mask(pg_size_e'(ent_size[lk_idx]));
    hit_pa   = {(ent_base[lk_idx] & hit_mask) |
                (lk_va[VA_W-1:TAG_LSB] & ~hit_mask),
                lk_va[TAG_LSB-1:0]};
  end

  // Single-slot result stage with valid/ready
  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_pa    <= '0;
      rs_size  <= '0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_hit   <= lk_any;
      rs_pa    <= lk_any ? hit_pa : '0;
      rs_size  <= lk_any ? ent_size[lk_idx] : 2'b00;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_multisize_chk.sv
module tlb_multisize_chk #(
  parameter  int N  = 64,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic          rs_valid,
  input logic          rs_ready,
  input logic          rs_hit,
  input logic [31:0]   rs_pa,
  input logic [1:0]    rs_size,
  input logic          rf_valid,
  input logic          rf_ready,
  input logic          inv_all,
  input logic          inv_one,
  input logic [IW-1:0] lock_base,
  input logic [N-1:0]  lk_match,
  input logic [N-1:0]  inv_match,
  input logic [N-1:0]  ent_valid,
  input logic [IW-1:0] victim
);
  logic [N-1:0] unl;
  always_comb begin
    for (int i = 0; i < N; i++) unl[i] = (i >= int'(lock_base));
  end

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rs_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_pa) && $stable(rs_hit) && $stable(rs_size));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_hit |-> rs_pa == 32'd0 && rs_size == 2'd0);

  assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && rf_ready |-> victim >= lock_base);

  assert_inv_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (ent_valid & $past(unl)) == '0);

  assert_inv_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_one |=> (ent_valid & $past(inv_match)) == '0);

  assert_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all || inv_one |=> $countones(ent_valid) <= $countones($past(ent_valid)));

  assert_unique_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

bind tlb_multisize tlb_multisize_chk #(.N(N_ENTRIES)) u_chk (.*);

// File: tb/tb_tlb_multisize.sv
module tb_tlb_multisize;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_va = '0;
  logic rs_valid, rs_ready = 1'b1, rs_hit;
  logic [31:0] rs_pa;
  logic [1:0] rs_size;
  logic rf_valid = 1'b0, rf_ready;
  logic [21:0] rf_tag = '0, rf_base = '0;
  logic [1:0] rf_size = '0;
  logic inv_all = 1'b0, inv_one = 1'b0;
  logic [21:0] inv_tag = '0;
  logic [5:0] lock_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_multisize dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // Reference model
  bit          m_v   [NE];
  logic [21:0] m_tag [NE];
  logic [21:0] m_base[NE];
  logic [1:0]  m_sz  [NE];
  int          m_ptr = 0;
  int          m_lock = 0;
  bit          m_seen[NE];

  function automatic logic [21:0] size_mask(logic [1:0] s);
    case (s)
      2'b00: return 22'h3FFC00;
      2'b01: return 22'h3FFFC0;
      2'b10: return 22'h3FFFFC;
      default: return 22'h3FFFFF;
    endcase
  endfunction

  function automatic void m_lookup(logic [31:0] va, output bit hit,
                                   output logic [31:0] pa, output logic [1:0] sz,
                                   output int nmatch);
    logic [21:0] mk;
    hit = 0; pa = '0; sz = '0; nmatch = 0;
    for (int i = NE - 1; i >= 0; i--) begin
      mk = size_mask(m_sz[i]);
      if (m_v[i] && (((m_tag[i] ^ va[31:10]) & mk) == '0)) begin
        nmatch++;
        hit = 1;
        sz  = m_sz[i];
        pa  = {(m_base[i] & mk) | (va[31:10] & ~mk), va[9:0]};
      end
    end
  endfunction

  function automatic bit m_overlap(logic [21:0] t, logic [1:0] s);
    for (int i = 0; i < NE; i++)
      if (m_v[i] && (((m_tag[i] ^ t) & size_mask(m_sz[i]) & size_mask(s)) == '0))
        return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_refill(logic [21:0] t, logic [21:0] b, logic [1:0] s);
    int v;
    @(negedge clk);
    rf_valid = 1; rf_tag = t; rf_base = b; rf_size = s;
    @(posedge clk);
    v = (m_ptr < m_lock) ? m_lock : m_ptr;
    m_v[v] = 1; m_tag[v] = t; m_base[v] = b; m_sz[v] = s; m_seen[v] = 1;
    m_ptr = (v == NE - 1) ? m_lock : v + 1;
    @(negedge clk);
    rf_valid = 0;
  endtask

  task automatic do_lookup(logic [31:0] va, string req);
    bit h; logic [31:0] pa; logic [1:0] sz; int n;
    m_lookup(va, h, pa, sz, n);
    @(negedge clk);
    lk_valid = 1; lk_va = va;
    @(posedge clk);
    #1;
    chk(req, {31'd0, rs_valid}, 32'd1);
    chk(req, {31'd0, rs_hit}, {31'd0, h});
    chk(req, rs_pa, pa);
    chk(req, {30'd0, rs_size}, {30'd0, sz});
    if (n > 1) chk("R10", n, 1);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic do_inv_all();
    @(negedge clk);
    inv_all = 1;
    @(posedge clk);
    for (int i = m_lock; i < NE; i++) m_v[i] = 0;
    @(negedge clk);
    inv_all = 0;
  endtask

  task automatic do_inv_one(logic [21:0] t);
    @(negedge clk);
    inv_one = 1; inv_tag = t;
    @(posedge clk);
    for (int i = 0; i < NE; i++)
      if (m_v[i] && (((m_tag[i] ^ t) & size_mask(m_sz[i])) == '0)) m_v[i] = 0;
    @(negedge clk);
    inv_one = 0;
  endtask

  task automatic set_lock(int l);
    @(negedge clk);
    lock_base = 6'(l); m_lock = l;
  endtask

  function automatic logic [31:0] va_in(int i);
    logic [21:0] mk = size_mask(m_sz[i]);
    logic [31:0] r  = $urandom();
    return {(m_tag[i] & mk) | (r[31:10] & ~mk), r[9:0]};
  endfunction

  task automatic random_refill();
    logic [1:0] s; logic [21:0] t;
    for (int k = 0; k < 30; k++) begin
      s = 2'($urandom());
      t = 22'($urandom());
      if (!m_overlap(t, s)) begin
        do_refill(t, 22'($urandom()), s);
        return;
      end
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < NE; i++)
      if (m_seen[i]) do_lookup(va_in(i), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_base[i] = '0; m_sz[i] = '0; m_seen[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk("R11", {31'd0, rs_valid}, 32'd0);
    chk("R11", {31'd0, lk_ready}, 32'd1);
    chk("R11", {31'd0, rf_ready}, 32'd1);
    do_lookup(32'h1234_5678, "R11");

    // R1, R2: one mapping of each size
    do_refill(22'(32'hB000_0000 >> 10), 22'(32'h3000_0000 >> 10), 2'b00);
    do_refill(22'(32'h1234_0000 >> 10), 22'(32'h5678_0000 >> 10), 2'b01);
    do_refill(22'(32'h0ABC_1000 >> 10), 22'(32'h0077_7000 >> 10), 2'b10);
    do_refill(22'(32'h0DEF_0400 >> 10), 22'(32'h1111_0800 >> 10), 2'b11);
    do_lookup(32'hB00F_4123, "R1");
    chk("R1", rs_pa, 32'h300F_4123);
    do_lookup(32'h1234_ABCD, "R2");
    chk("R2", rs_pa, 32'h5678_ABCD);
    do_lookup(32'h0ABC_1FFF, "R2");
    do_lookup(32'h0DEF_07AB, "R2");
    chk("R2", rs_pa, 32'h1111_0BAB);
    do_lookup(32'h0DEF_0800, "R2");   // neighbouring tiny page misses
    do_lookup(32'h0ABC_2000, "R4");   // neighbouring small page misses

    // R3: back-pressure
    @(negedge clk);
    rs_ready = 0; lk_valid = 1; lk_va = 32'hB000_0010;
    @(posedge clk); #1;
    chk("R3", {31'd0, rs_valid}, 32'd1);
    chk("R3", rs_pa, 32'h3000_0010);
    @(negedge clk);
    lk_va = 32'h1234_0001;
    #1;
    chk("R3", {31'd0, lk_ready}, 32'd0);
    @(posedge clk); #1;
    chk("R3", rs_pa, 32'h3000_0010);
    @(negedge clk);
    rs_ready = 1;
    #1;
    chk("R3", {31'd0, lk_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R3", rs_pa, 32'h5678_0001);
    @(negedge clk);
    lk_valid = 0;

    // R6: lock the four directed entries, then churn
    set_lock(4);
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom() % 100);
      if (op < 50) random_refill();
      else if (op < 80) begin
        int e = int'($urandom() % NE);
        if (m_seen[e]) do_lookup(va_in(e), "R5");
      end else if (op < 88) do_lookup($urandom(), "R4");
      else if (op < 94) begin
        int e = 4 + int'($urandom() % (NE - 4));
        if (m_v[e]) do_inv_one(m_tag[e]);
      end else if (op < 96) do_inv_all();
      else do_lookup(va_in(int'($urandom() % 4)), "R6");
    end
    sweep("R10");
    for (int i = 0; i < 4; i++) do_lookup(va_in(i), "R6");

    // R7: invalidate all keeps locked entries
    do_inv_all();
    sweep("R7");
    do_lookup(32'hB000_0044, "R7");
    chk("R7", {31'd0, rs_hit}, 32'd1);

    // R5: pointer wrap inside unlocked region with lock 60
    set_lock(60);
    for (int i = 0; i < 10; i++) random_refill();
    sweep("R5");

    // R9: invalidate, refill and lookup in one cycle
    @(negedge clk);
    inv_one = 1; inv_tag = 22'(32'hB000_0000 >> 10);
    rf_valid = 1; rf_tag = 22'(32'hFFF0_0000 >> 10); rf_base = 22'h1; rf_size = 2'b00;
    lk_valid = 1; lk_va = 32'hB000_0010;
    #1;
    chk("R9", {31'd0, rf_ready}, 32'd0);
    @(posedge clk); #1;
    chk("R9", {31'd0, rs_hit}, 32'd1);
    chk("R9", rs_pa, 32'h3000_0010);
    for (int i = 0; i < NE; i++)
      if (m_v[i] && (((m_tag[i] ^ inv_tag) & size_mask(m_sz[i])) == '0)) m_v[i] = 0;
    @(negedge clk);
    inv_one = 0; rf_valid = 0; lk_valid = 0;
    // R8: locked section entry is gone
    do_lookup(32'hB000_0010, "R8");
    chk("R8", {31'd0, rs_hit}, 32'd0);
    do_lookup(32'hFFF0_0123, "R9");
    sweep("R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule